// File: doc/BRIEF.md
# Interrupt Line and Target Level Router

This block sits between an interrupt source collector and a processor's exception entry logic. Each pending source carries a group tag that says which software layer owns it. The block compares that tag with the processor's current security state and decides two things. First, whether the source is signalled on the fast line (FIQ) or the normal line (IRQ). Second, which exception level the resulting exception targets.

The block also keeps the processor's current exception level, its security state and a pair of mask bits (IRQ, FIQ) for each level. From these it decides whether the exception is taken now or stays pending. When it is taken, the block emits a one-cycle strobe with the chosen line and target level. It then moves its state to the target level with that level's masks set. An exception return loads the whole state from a saved-state input in a single cycle.

Top module: `irq_route_top`

## Requirements
- R1: After synchronous reset the state is EL3, Secure, all eight mask bits set, and the take strobe is low.
- R2: Group tags are encoded 0 = Group 0 (Secure), 1 = Secure Group 1, 2 = Non-secure Group 1, 3 = treated as Group 0. Group 0 always goes to FIQ. A Group 1 source whose security matches the current state goes to IRQ; one of the other security state goes to FIQ. Line encoding: 0 = IRQ, 1 = FIQ.
- R3: An exception taken on FIQ always targets EL3 (level code 3).
- R4: An IRQ in Secure state targets EL1. An IRQ in Non-secure state targets EL2 when `hyp_irq_to_el2` is 1, otherwise EL1.
- R5: An exception whose target is below the current level is not taken. It stays pending and is taken once a return lowers the level.
- R6: An exception whose target equals the current level is not taken while that level's mask for its line is set. It is taken when that mask is clear.
- R7: An exception whose target is above the current level is taken whatever the current level's masks are.
- R8: On a take, the current level becomes the target level and both masks of the target level are set. The security state becomes Secure on FIQ and is otherwise kept. The masks of the other levels are unchanged.
- R9: A return (`ret_valid`) loads level, security state and all masks in one cycle. It overrides any take in that cycle.
- R10: When both lines qualify in the same cycle, FIQ is taken.
- R11: The take strobe, line and level appear one clock after the qualifying inputs. The strobe lasts one cycle for each decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pend | input | NSRC | Per-source pending flags |
| src_grp | input | 2*NSRC | Per-source group tags, 2 bits each |
| hyp_irq_to_el2 | input | 1 | Non-secure IRQ routing: 1 = EL2, 0 = EL1 |
| ret_valid | input | 1 | Exception return: load saved state |
| ret_level | input | 2 | Saved exception level |
| ret_secure | input | 1 | Saved security state, 1 = Secure |
| ret_irq_mask | input | 4 | Saved IRQ mask per level, bit n = ELn |
| ret_fiq_mask | input | 4 | Saved FIQ mask per level, bit n = ELn |
| take_o | output | 1 | One-cycle exception take strobe |
| take_line_o | output | 1 | Line of the last take, 0 = IRQ, 1 = FIQ |
| take_level_o | output | 2 | Target level of the last take |
| cur_level_o | output | 2 | Current exception level |
| cur_secure_o | output | 1 | Current security state |
| irq_mask_o | output | 4 | IRQ mask per level |
| fiq_mask_o | output | 4 | FIQ mask per level |

## Verification
The assertions check the following on every cycle:
- Every FIQ take lands at EL3.
- No take lands below the level held one cycle earlier.
- A take at the same level only happens with that line's mask clear.
- Each take leaves the state at the target level with both masks set.
- A return loads its saved level without a take.
- FIQ wins whenever both lines qualify.

Only the bench scenarios show the rest:
- The group-to-line mapping across both security states.
- The routing bit for Non-secure IRQs.
- That a held interrupt is finally taken after a return lowers the level.
- That masks of other levels survive a take.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int NLVL = 4;
    localparam int LVLW = $clog2(NLVL);
    localparam int GRPW = 2;

    typedef logic [LVLW-1:0] level_t;

    localparam level_t EL1 = level_t'(1);
    localparam level_t EL2 = level_t'(2);
    localparam level_t EL3 = level_t'(3);

    typedef enum logic [GRPW-1:0] {
        GRP_SEC0 = 2'd0,
        GRP_SEC1 = 2'd1,
        GRP_NS1  = 2'd2,
        GRP_RSVD = 2'd3
    } grp_t;

    typedef enum logic {
        LINE_IRQ = 1'b0,
        LINE_FIQ = 1'b1
    } line_t;

    typedef struct packed {
        logic   take;
        line_t  line;
        level_t level;
    } decision_t;

    // Line choice for one group tag seen from the current security state.
    function automatic line_t group_line(input grp_t g, input logic secure);
        case (g)
            GRP_SEC1: group_line = secure  ? LINE_IRQ : LINE_FIQ;
            GRP_NS1:  group_line = !secure ? LINE_IRQ : LINE_FIQ;
            default:  group_line = LINE_FIQ;
        endcase
    endfunction

    // Target level of the normal line.
    function automatic level_t irq_target(input logic secure, input logic to_el2);
        irq_target = (!secure && to_el2) ? EL2 : EL1;
    endfunction

    // Taken now: target above current, or equal with the mask clear.
    function automatic logic can_take(input level_t tgt, input level_t cur,
                                      input logic mask_at_cur);
        can_take = (tgt > cur) || ((tgt == cur) && !mask_at_cur);
    endfunction

endpackage

// File: rtl/irq_route_classify.sv
module irq_route_classify
    import irq_route_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic [NSRC-1:0]      pend,
    input  logic [GRPW*NSRC-1:0] grp,
    input  logic                 secure,
    output logic                 fiq_req,
    output logic                 irq_req
);
    logic [NSRC-1:0] is_fiq;
    logic [NSRC-1:0] is_irq;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        line_t ln;
        assign ln        = group_line(grp_t'(grp[i*GRPW +: GRPW]), secure);
        assign is_fiq[i] = pend[i] && (ln == LINE_FIQ);
        assign is_irq[i] = pend[i] && (ln == LINE_IRQ);
    end

    assign fiq_req = |is_fiq;
    assign irq_req = |is_irq;

endmodule

// File: rtl/irq_route_gate.sv
module irq_route_gate
    import irq_route_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            fiq_req,
    input  logic            irq_req,
    input  level_t          cur_level,
    input  logic            secure,
    input  logic            to_el2,
    input  logic [NLVL-1:0] irq_mask,
    input  logic [NLVL-1:0] fiq_mask,
    output decision_t       dec
);
    level_t irq_tgt;
    logic   fiq_ok;
    logic   irq_ok;

    assign irq_tgt = irq_target(secure, to_el2);
    assign fiq_ok  = fiq_req && can_take(EL3, cur_level, fiq_mask[cur_level]);
    assign irq_ok  = irq_req && can_take(irq_tgt, cur_level, irq_mask[cur_level]);

    always_comb begin
        dec.take  = fiq_ok || irq_ok;
        dec.line  = fiq_ok ? LINE_FIQ : LINE_IRQ;
        dec.level = fiq_ok ? EL3 : irq_tgt;
    end

    // R10: the fast line wins when both qualify
    p_fiq_first_r10: assert property (@(posedge clk) disable iff (rst)
        (fiq_ok && irq_ok) |-> (dec.line == LINE_FIQ && dec.level == EL3));

endmodule

// File: rtl/irq_route_state.sv
module irq_route_state
    import irq_route_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  decision_t       dec,
    input  logic            ret_valid,
    input  level_t          ret_level,
    input  logic            ret_secure,
    input  logic [NLVL-1:0] ret_irq_mask,
    input  logic [NLVL-1:0] ret_fiq_mask,
    output logic            take_q,
    output line_t           line_q,
    output level_t          tlevel_q,
    output level_t          level_q,
    output logic            secure_q,
    output logic [NLVL-1:0] irq_mask_q,
    output logic [NLVL-1:0] fiq_mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            take_q     <= 1'b0;
            line_q     <= LINE_IRQ;
            tlevel_q   <= '0;
            level_q    <= EL3;
            secure_q   <= 1'b1;
            irq_mask_q <= '1;
            fiq_mask_q <= '1;
        end else if (ret_valid) begin
            take_q     <= 1'b0;
            level_q    <= ret_level;
            secure_q   <= ret_secure;
            irq_mask_q <= ret_irq_mask;
            fiq_mask_q <= ret_fiq_mask;
        end else begin
            take_q <= dec.take;
            if (dec.take) begin
                line_q                <= dec.line;
                tlevel_q              <= dec.level;
                level_q               <= dec.level;
                irq_mask_q[dec.level] <= 1'b1;
                fiq_mask_q[dec.level] <= 1'b1;
                if (dec.line == LINE_FIQ) secure_q <= 1'b1;
            end
        end
    end

    // R3: every fast-line take lands at EL3
    p_fiq_el3_r3: assert property (@(posedge clk) disable iff (rst)
        (take_q && line_q == LINE_FIQ) |-> (tlevel_q == EL3));

    // R5: never taken to a level below the one held before
    p_no_lower_r5: assert property (@(posedge clk) disable iff (rst)
        take_q |-> (tlevel_q >= $past(level_q)));

    // R6: same-level IRQ take needs that level's IRQ mask clear
    p_irq_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (take_q && line_q == LINE_IRQ && tlevel_q == $past(level_q))
            |-> !$past(irq_mask_q[level_q]));

    // R6: same-level FIQ take needs that level's FIQ mask clear
    p_fiq_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (take_q && line_q == LINE_FIQ && tlevel_q == $past(level_q))
            |-> !$past(fiq_mask_q[level_q]));

    // R8: entry leaves state at the target with both masks set
    p_entry_state_r8: assert property (@(posedge clk) disable iff (rst)
        take_q |-> (level_q == tlevel_q && irq_mask_q[tlevel_q] && fiq_mask_q[tlevel_q]));

    // R9: a return loads its level and suppresses a take
    p_ret_load_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(ret_valid) && !$past(rst)) |-> (level_q == $past(ret_level) && !take_q));

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
    import irq_route_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NSRC-1:0]      src_pend,
    input  logic [GRPW*NSRC-1:0] src_grp,
    input  logic                 hyp_irq_to_el2,
    input  logic                 ret_valid,
    input  logic [LVLW-1:0]      ret_level,
    input  logic                 ret_secure,
    input  logic [NLVL-1:0]      ret_irq_mask,
    input  logic [NLVL-1:0]      ret_fiq_mask,
    output logic                 take_o,
    output logic                 take_line_o,
    output logic [LVLW-1:0]      take_level_o,
    output logic [LVLW-1:0]      cur_level_o,
    output logic                 cur_secure_o,
    output logic [NLVL-1:0]      irq_mask_o,
    output logic [NLVL-1:0]      fiq_mask_o
);
    logic      fiq_req;
    logic      irq_req;
    decision_t dec;
    line_t     line_q;
    level_t    tlevel_q;
    level_t    level_q;

    irq_route_classify #(.NSRC(NSRC)) u_classify (
        .pend    (src_pend),
        .grp     (src_grp),
        .secure  (cur_secure_o),
        .fiq_req (fiq_req),
        .irq_req (irq_req)
    );

    irq_route_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .fiq_req   (fiq_req),
        .irq_req   (irq_req),
        .cur_level (level_q),
        .secure    (cur_secure_o),
        .to_el2    (hyp_irq_to_el2),
        .irq_mask  (irq_mask_o),
        .fiq_mask  (fiq_mask_o),
        .dec       (dec)
    );

    irq_route_state u_state (
        .clk          (clk),
        .rst          (rst),
        .dec          (dec),
        .ret_valid    (ret_valid),
        .ret_level    (level_t'(ret_level)),
        .ret_secure   (ret_secure),
        .ret_irq_mask (ret_irq_mask),
        .ret_fiq_mask (ret_fiq_mask),
        .take_q       (take_o),
        .line_q       (line_q),
        .tlevel_q     (tlevel_q),
        .level_q      (level_q),
        .secure_q     (cur_secure_o),
        .irq_mask_q   (irq_mask_o),
        .fiq_mask_q   (fiq_mask_o)
    );

    assign take_line_o  = line_q;
    assign take_level_o = tlevel_q;
    assign cur_level_o  = level_q;

endmodule

// File: tb/sim_irq_route_top.sv
module sim_irq_route_top;
    localparam int NSRC = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_pend = '0;
    logic [2*NSRC-1:0] src_grp = '0;
    logic            hyp_irq_to_el2 = 1'b0;
    logic            ret_valid = 1'b0;
    logic [1:0]      ret_level = '0;
    logic            ret_secure = 1'b0;
    logic [3:0]      ret_irq_mask = '0;
    logic [3:0]      ret_fiq_mask = '0;
    logic            take_o;
    logic            take_line_o;
    logic [1:0]      take_level_o;
    logic [1:0]      cur_level_o;
    logic            cur_secure_o;
    logic [3:0]      irq_mask_o;
    logic [3:0]      fiq_mask_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_route_top #(.NSRC(NSRC)) u0 (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_ret(input logic [1:0] lv, input logic sec,
                          input logic [3:0] im, input logic [3:0] fm);
        ret_level = lv; ret_secure = sec; ret_irq_mask = im; ret_fiq_mask = fm;
        ret_valid = 1'b1;
        tick();
        ret_valid = 1'b0;
    endtask

    // One source pending for one cycle, outputs sampled after the edge.
    task automatic fire(input int src, input logic [1:0] grp);
        src_grp[src*2 +: 2] = grp;
        src_pend = '0;
        src_pend[src] = 1'b1;
        tick();
        src_pend = '0;
    endtask

    task automatic t_reset();
        check("R1 level", cur_level_o, 3);
        check("R1 secure", cur_secure_o, 1);
        check("R1 irq masks", irq_mask_o, 15);
        check("R1 fiq masks", fiq_mask_o, 15);
        check("R1 take", take_o, 0);
    endtask

    task automatic t_ns_irq_el1();
        hyp_irq_to_el2 = 1'b0;
        do_ret(2'd0, 1'b0, 4'b0000, 4'b0000);
        src_grp[1:0] = 2'd2;
        src_pend = 4'b0001;
        tick();
        check("R2 ns1 in ns is irq", take_line_o, 0);
        check("R4 ns irq to el1", take_level_o, 1);
        check("R11 strobe", take_o, 1);
        check("R8 level", cur_level_o, 1);
        check("R8 secure kept", cur_secure_o, 0);
        check("R8 irq masks", irq_mask_o, 4'b0010);
        check("R8 fiq masks", fiq_mask_o, 4'b0010);
        tick();
        check("R11 single pulse", take_o, 0);
        src_pend = '0;
    endtask

    task automatic t_route_el2();
        hyp_irq_to_el2 = 1'b1;
        do_ret(2'd1, 1'b0, 4'b0010, 4'b0010);
        fire(0, 2'd2);
        check("R7 above masked level taken", take_o, 1);
        check("R4 ns irq to el2", take_level_o, 2);
        check("R4 line", take_line_o, 0);
        hyp_irq_to_el2 = 1'b0;
    endtask

    task automatic t_sec_irq();
        hyp_irq_to_el2 = 1'b1;
        do_ret(2'd0, 1'b1, 4'b0000, 4'b0000);
        fire(3, 2'd1);
        check("R2 sec1 in secure is irq", take_line_o, 0);
        check("R4 secure irq to el1", take_level_o, 1);
        check("R4 take", take_o, 1);
        hyp_irq_to_el2 = 1'b0;
    endtask

    task automatic t_fiq();
        do_ret(2'd1, 1'b0, 4'b0000, 4'b0000);
        fire(2, 2'd1);
        check("R2 sec1 in ns is fiq", take_line_o, 1);
        check("R3 fiq to el3", take_level_o, 3);
        check("R8 fiq sets secure", cur_secure_o, 1);
        check("R8 other masks kept", irq_mask_o, 4'b1000);
        do_ret(2'd0, 1'b0, 4'b0000, 4'b0000);
        fire(1, 2'd0);
        check("R2 group0 is fiq", take_line_o, 1);
        check("R3 group0 to el3", take_level_o, 3);
        do_ret(2'd1, 1'b1, 4'b0000, 4'b0000);
        fire(0, 2'd2);
        check("R2 ns1 in secure is fiq", take_line_o, 1);
        do_ret(2'd0, 1'b1, 4'b0000, 4'b0000);
        fire(0, 2'd3);
        check("R2 tag 3 is fiq", take_line_o, 1);
        check("R2 tag 3 taken", take_o, 1);
    endtask

    task automatic t_below();
        do_ret(2'd3, 1'b1, 4'b0000, 4'b0000);
        fire(0, 2'd1);
        check("R5 secure irq at el3 held", take_o, 0);
        do_ret(2'd2, 1'b0, 4'b0000, 4'b0000);
        src_grp[1:0] = 2'd2;
        src_pend = 4'b0001;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R5 below held", take_o, 0);
        end
        do_ret(2'd0, 1'b0, 4'b0000, 4'b0000);
        check("R5 return cycle", take_o, 0);
        tick();
        check("R5 taken after drop", take_o, 1);
        check("R5 level", take_level_o, 1);
        src_pend = '0;
    endtask

    task automatic t_masked();
        do_ret(2'd1, 1'b0, 4'b0010, 4'b0000);
        fire(0, 2'd2);
        check("R6 masked irq held", take_o, 0);
        check("R6 level kept", cur_level_o, 1);
        do_ret(2'd1, 1'b0, 4'b0000, 4'b0010);
        fire(0, 2'd2);
        check("R6 unmasked irq taken", take_o, 1);
        do_ret(2'd3, 1'b1, 4'b0000, 4'b1000);
        fire(0, 2'd0);
        check("R6 masked fiq held", take_o, 0);
        do_ret(2'd3, 1'b1, 4'b1000, 4'b0000);
        fire(0, 2'd0);
        check("R6 unmasked fiq taken", take_o, 1);
        check("R6 fiq masks", fiq_mask_o, 4'b1000);
    endtask

    task automatic t_ret_override();
        do_ret(2'd0, 1'b0, 4'b0000, 4'b0000);
        src_grp[1:0] = 2'd2;
        src_pend = 4'b0001;
        do_ret(2'd2, 1'b0, 4'b0101, 4'b1010);
        check("R9 take suppressed", take_o, 0);
        check("R9 level", cur_level_o, 2);
        check("R9 secure", cur_secure_o, 0);
        check("R9 irq masks", irq_mask_o, 4'b0101);
        check("R9 fiq masks", fiq_mask_o, 4'b1010);
        src_pend = '0;
    endtask

    task automatic t_fiq_first();
        do_ret(2'd0, 1'b0, 4'b0000, 4'b0000);
        src_grp = {2'd0, 2'd0, 2'd0, 2'd2};
        src_pend = 4'b0011;
        tick();
        check("R10 fiq first line", take_line_o, 1);
        check("R10 fiq first level", take_level_o, 3);
        tick();
        check("R10 irq held at el3", take_o, 0);
        src_pend = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        t_reset();
        t_ns_irq_el1();
        t_route_el2();
        t_sec_irq();
        t_fiq();
        t_below();
        t_masked();
        t_ret_override();
        t_fiq_first();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule